// File: doc/BRIEF.md
# Banked Host Register File

This block is the host-facing register bank of a network interface. It keeps 24 byte-wide registers in three groups of eight. The address group and the configuration group share one eight-port window. A switch bit in the hardware-support register picks which of the two appears there. The control group sits in the other eight ports and is always reachable. The control register drives a reset line to the attached network controller and an enable for host access to shared buffer memory.

The address and configuration groups can be loaded from a nonvolatile store. If the strap pins carry the code 1001 when reset ends, an initialisation recall starts on the first cycle after reset. Software can also start a recall by writing a command bit, and that recall reads a second set of words. The store is read one word at a time through a request/acknowledge handshake, with a fixed wait between words. The fetched words are held in a staging buffer and copied into the registers in a single cycle at the end. A busy flag can be read throughout the recall.

Top module: `host_reg_bank`

## Requirements
- R1: After reset, the control register (port 0) reads 0x80 and every other port reads 0x00. nicReset is 1 and memEnable is 0.
- R2: Ports 0–7 are control-group registers 0–7. Ports 8–15 form the window. Bit 7 of the hardware-support register (port 2) is the switch: when it is 0 the window shows address registers 0–7, and when it is 1 it shows configuration registers 0–7. The two groups keep separate contents.
- R3: The control group reads and writes the same way whatever the switch setting.
- R4: Control register bit 7 drives nicReset and bit 6 drives memEnable. Bit 5 always reads 0. Bits 4:0 are plain read/write storage.
- R5: A recall starts right after reset only if the strap equals 1001 on the last reset clock. From the first cycle after reset the busy flag is set. Any other strap value on that clock leaves the block idle and makes no store request.
- R6: A recall fetches 16 words in index order. Each request holds nvReq high with a stable nvAddr until nvAck is seen, then waits STEP_CYCLES cycles before the next request. nvAddr bit 4 selects the set (0 for the initialisation recall, 1 for a software recall). nvAddr bits 3:0 give the index: indices 0–7 load address registers 0–7 and indices 8–15 load configuration registers 0–7.
- R7: While a recall runs, the address and configuration registers keep their previous values. All 16 fetched words take effect together when the recall completes.
- R8: When an initialisation recall completes, control bit 7 is forced to 0. A software recall leaves the control register unchanged.
- R9: Writing port 1 with bit 0 set while idle starts a software recall.
- R10: Port 1 reads bit 7 as busy and bits 3:0 as the live strap pins, with all other bits 0. Values written to port 1 are not read back.
- R11: While busy, host writes to the window are ignored. Writes to the control group are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strap | input | 4 | Strap pins; sampled for the recall code during reset |
| hostAddr | input | 4 | Host port number |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data for hostAddr (combinational) |
| nvReq | output | 1 | Store word request |
| nvAddr | output | 5 | Store word address: set bit and index |
| nvAck | input | 1 | Store acknowledge; nvData is valid with it |
| nvData | input | 8 | Store word data |
| nicReset | output | 1 | Reset to the attached network controller |
| memEnable | output | 1 | Host shared-memory access enable |

## Verification
The bench writes different bytes into the two window groups and flips the switch between them. A design that shared the storage, or decoded the switch backwards, would return the wrong byte. During a recall it reads and writes the window to show that the old values hold and that host writes do not land. A design that updated in place, or let writes through, would show the new byte straight away. It checks that the initialisation recall releases nicReset and that a software recall leaves it alone, and that each recall uses the correct set bit and index order. It also changes the strap away from 1001 on the final reset clock, which catches a design that samples the strap too early.

// File: rtl/hrb_pkg.sv
package hrb_pkg;
  localparam int REG_W     = 8;
  localparam int GRP_REGS  = 8;
  localparam int GRP_IDX_W = $clog2(GRP_REGS);
  localparam int PORT_W    = GRP_IDX_W + 1;
  localparam int REC_REGS  = 2 * GRP_REGS;
  localparam int REC_IDX_W = $clog2(REC_REGS);

  // strobes from the recall sequencer to the register datapath
  typedef struct packed {
    logic                 stageWe;
    logic [REC_IDX_W-1:0] stageIdx;
    logic                 commit;
    logic                 initSet;
    logic                 busy;
  } recallStrobe_t;
endpackage

// File: rtl/hrb_recall_ctrl.sv
module hrb_recall_ctrl
  import hrb_pkg::*;
#(
  parameter int                 STEP_CYCLES = 8,
  parameter int                 STRAP_W     = 4,
  parameter logic [STRAP_W-1:0] STRAP_CODE  = 4'b1001
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  logic                 recallStart,
  input  logic                 nvAck,
  output logic                 nvReq,
  output logic [REC_IDX_W:0]   nvAddr,
  output recallStrobe_t        strobe
);
  localparam int GAP_W = $clog2(STEP_CYCLES + 1);
  localparam logic [GAP_W-1:0]     GAP_LAST = GAP_W'(STEP_CYCLES - 1);
  localparam logic [REC_IDX_W-1:0] IDX_LAST = REC_IDX_W'(REC_REGS - 1);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP, S_COMMIT} state_t;

  state_t               state;
  logic                 pendInit;
  logic                 setSel;
  logic [REC_IDX_W-1:0] idx;
  logic [GAP_W-1:0]     gapCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendInit <= (strap == STRAP_CODE);
      setSel   <= 1'b0;
      idx      <= '0;
      gapCnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (pendInit || recallStart) begin
          state    <= S_REQ;
          setSel   <= !pendInit;
          pendInit <= 1'b0;
          idx      <= '0;
        end
        S_REQ: if (nvAck) begin
          state  <= S_GAP;
          gapCnt <= '0;
        end
        S_GAP: begin
          if (gapCnt == GAP_LAST) begin
            if (idx == IDX_LAST) state <= S_COMMIT;
            else begin
              idx   <= idx + 1'b1;
              state <= S_REQ;
            end
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        S_COMMIT: state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign nvReq  = (state == S_REQ);
  assign nvAddr = {setSel, idx};

  always_comb begin
    strobe.stageWe  = (state == S_REQ) && nvAck;
    strobe.stageIdx = idx;
    strobe.commit   = (state == S_COMMIT);
    strobe.initSet  = !setSel;
    strobe.busy     = (state != S_IDLE) || pendInit;
  end

  // R6: a request holds steady until acknowledged
  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    nvReq && !nvAck |=> nvReq && $stable(nvAddr));

  // R9: a start while idle makes the block busy
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    recallStart && !strobe.busy |=> strobe.busy);

  // R7: commit is the final step of a recall
  assert_commit_ends_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> !strobe.busy);
endmodule

// File: rtl/hrb_regs.sv
module hrb_regs
  import hrb_pkg::*;
#(
  parameter int                 STRAP_W  = 4,
  parameter logic [REG_W-1:0]   CTRL_RST = 8'h80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  logic [PORT_W-1:0]    hostAddr,
  input  logic                 hostWr,
  input  logic [REG_W-1:0]     hostWdata,
  output logic [REG_W-1:0]     hostRdata,
  input  logic [REG_W-1:0]     nvData,
  input  recallStrobe_t        strobe,
  output logic                 recallStart,
  output logic                 nicReset,
  output logic                 memEnable
);
  localparam logic [GRP_IDX_W-1:0] IX_CTRL = GRP_IDX_W'(0);
  localparam logic [GRP_IDX_W-1:0] IX_NV   = GRP_IDX_W'(1);
  localparam logic [GRP_IDX_W-1:0] IX_HW   = GRP_IDX_W'(2);
  localparam logic [REG_W-1:0]     CTRL_MASK = ~(REG_W'(1) << 5);
  localparam int                   PAD_W = REG_W - 1 - STRAP_W;

  logic [GRP_IDX_W-1:0] cIdx;
  logic                 inWindow, switchOn, ctlWr, winWr;
  logic [REC_IDX_W-1:0] winIdx;
  logic [REG_W-1:0]     ctrlReg, hwReg, nvStatus;
  logic [GRP_REGS-1:0][REG_W-1:0] ctlView;
  logic [REC_REGS-1:0][REG_W-1:0] recRegs, stage;

  assign cIdx     = hostAddr[GRP_IDX_W-1:0];
  assign inWindow = hostAddr[PORT_W-1];
  assign switchOn = hwReg[REG_W-1];
  assign winIdx   = {switchOn, cIdx};
  assign ctlWr    = hostWr && !inWindow;
  assign winWr    = hostWr && inWindow && !strobe.busy;
  assign nvStatus = {strobe.busy, {PAD_W{1'b0}}, strap};

  assign recallStart = ctlWr && (cIdx == IX_NV) && hostWdata[0] && !strobe.busy;
  assign nicReset    = ctrlReg[7];
  assign memEnable   = ctrlReg[6];

  // recallable groups: staging buffer plus live registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      recRegs <= '0;
      stage   <= '0;
    end else begin
      if (strobe.stageWe) stage[strobe.stageIdx] <= nvData;
      if (winWr)          recRegs[winIdx] <= hostWdata;
      if (strobe.commit)  recRegs <= stage;
    end
  end

  // control group, one slot per port
  for (genvar g = 0; g < GRP_REGS; g++) begin : g_ctl
    if (g == 0) begin : g_ctrl
      always_ff @(posedge clk) begin
        if (!rstN) ctrlReg <= CTRL_RST;
        else begin
          if (ctlWr && cIdx == IX_CTRL) ctrlReg <= hostWdata & CTRL_MASK;
          if (strobe.commit && strobe.initSet) ctrlReg[7] <= 1'b0;
        end
      end
      assign ctlView[g] = ctrlReg;
    end else if (g == 1) begin : g_nv
      assign ctlView[g] = nvStatus;
    end else if (g == 2) begin : g_hw
      always_ff @(posedge clk) begin
        if (!rstN) hwReg <= '0;
        else if (ctlWr && cIdx == IX_HW) hwReg <= hostWdata;
      end
      assign ctlView[g] = hwReg;
    end else begin : g_spare
      logic [REG_W-1:0] spareReg;
      always_ff @(posedge clk) begin
        if (!rstN) spareReg <= '0;
        else if (ctlWr && cIdx == GRP_IDX_W'(g)) spareReg <= hostWdata;
      end
      assign ctlView[g] = spareReg;
    end
  end

  assign hostRdata = inWindow ? recRegs[winIdx] : ctlView[cIdx];

  // R7 and R11: recallable registers are frozen until the commit cycle
  assert_recall_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.busy && !strobe.commit |=> $stable(recRegs));

  // R8: an initialisation recall releases the controller reset
  assert_init_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit && strobe.initSet |=> !nicReset);
endmodule

// File: rtl/host_reg_bank.sv
module host_reg_bank
  import hrb_pkg::*;
#(
  parameter int                 STEP_CYCLES = 8,
  parameter int                 STRAP_W     = 4,
  parameter logic [STRAP_W-1:0] STRAP_CODE  = 4'b1001,
  parameter logic [7:0]         CTRL_RST    = 8'h80
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [STRAP_W-1:0]   strap,
  input  logic [PORT_W-1:0]    hostAddr,
  input  logic                 hostWr,
  input  logic [REG_W-1:0]     hostWdata,
  output logic [REG_W-1:0]     hostRdata,
  output logic                 nvReq,
  output logic [REC_IDX_W:0]   nvAddr,
  input  logic                 nvAck,
  input  logic [REG_W-1:0]     nvData,
  output logic                 nicReset,
  output logic                 memEnable
);
  recallStrobe_t strobe;
  logic          recallStart;

  hrb_recall_ctrl #(
    .STEP_CYCLES(STEP_CYCLES), .STRAP_W(STRAP_W), .STRAP_CODE(STRAP_CODE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .strap(strap), .recallStart(recallStart),
    .nvAck(nvAck), .nvReq(nvReq), .nvAddr(nvAddr), .strobe(strobe)
  );

  hrb_regs #(.STRAP_W(STRAP_W), .CTRL_RST(CTRL_RST)) u_regs (
    .clk(clk), .rstN(rstN), .strap(strap), .hostAddr(hostAddr),
    .hostWr(hostWr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .nvData(nvData), .strobe(strobe), .recallStart(recallStart),
    .nicReset(nicReset), .memEnable(memEnable)
  );
endmodule

// File: tb/host_reg_bank_bench.sv
`timescale 1ns/1ps
module host_reg_bank_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] strap = 4'h0;
  logic [3:0] hostAddr = 4'h0;
  logic       hostWr = 1'b0;
  logic [7:0] hostWdata = 8'h00;
  logic [7:0] hostRdata;
  logic       nvReq;
  logic [4:0] nvAddr;
  logic       nvAck;
  logic [7:0] nvData;
  logic       nicReset, memEnable;

  int checks = 0, errors = 0;
  int ackCount = 0, expIdx = 0;
  bit seqOk = 1'b1;
  logic expSet = 1'b0;

  always #10 clk = ~clk;

  host_reg_bank u_host_reg_bank (
    .clk(clk), .rstN(rstN), .strap(strap), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .nvReq(nvReq), .nvAddr(nvAddr),
    .nvAck(nvAck), .nvData(nvData), .nicReset(nicReset), .memEnable(memEnable)
  );

  function automatic logic [7:0] nvVal(logic [4:0] a);
    return (a[4] ? 8'hC0 : 8'h40) | {4'h0, a[3:0]};
  endfunction

  // store model: acknowledges one cycle after a request and logs the order (R6)
  initial begin
    nvAck = 1'b0; nvData = 8'h00;
    forever begin
      @(posedge clk);
      if (nvReq && !nvAck) begin
        nvAck  <= 1'b1;
        nvData <= nvVal(nvAddr);
        if (nvAddr !== {expSet, expIdx[3:0]}) seqOk = 1'b0;
        ackCount++;
        expIdx++;
      end else begin
        nvAck <= 1'b0;
      end
    end
  end

  typedef struct packed {
    logic       wr;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t VEC [17] = '{
    '{1'b1, 4'h8, 8'h11, 8'h00, 4'd2},  // R2 address group 0
    '{1'b0, 4'h8, 8'h00, 8'h11, 4'd2},  // R2
    '{1'b1, 4'h2, 8'h80, 8'h00, 4'd2},  // R2 switch on
    '{1'b0, 4'h8, 8'h00, 8'h00, 4'd2},  // R2 config group still clear
    '{1'b1, 4'h8, 8'h22, 8'h00, 4'd2},  // R2
    '{1'b0, 4'h8, 8'h00, 8'h22, 4'd2},  // R2
    '{1'b0, 4'h0, 8'h00, 8'h80, 4'd3},  // R3 control visible with switch on
    '{1'b0, 4'h2, 8'h00, 8'h80, 4'd3},  // R3
    '{1'b1, 4'h2, 8'h00, 8'h00, 4'd2},  // R2 switch off
    '{1'b0, 4'h8, 8'h00, 8'h11, 4'd2},  // R2 address group kept its byte
    '{1'b0, 4'h9, 8'h00, 8'h00, 4'd2},  // R2
    '{1'b1, 4'h0, 8'hFF, 8'h00, 4'd4},  // R4
    '{1'b0, 4'h0, 8'h00, 8'hDF, 4'd4},  // R4 bit 5 reads 0
    '{1'b1, 4'h0, 8'h15, 8'h00, 4'd4},  // R4
    '{1'b0, 4'h0, 8'h00, 8'h15, 4'd4},  // R4
    '{1'b1, 4'h1, 8'hFE, 8'h00, 4'd10}, // R10 write without command bit
    '{1'b0, 4'h1, 8'h00, 8'h00, 4'd10}  // R10 nothing read back
  };

  task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    hostAddr = a;
    #1 v = hostRdata;
  endtask

  task automatic doReset(logic [3:0] s, logic [3:0] sLast);
    @(negedge clk);
    rstN = 1'b0; strap = s;
    repeat (3) @(negedge clk);
    strap = sLast;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitIdle(string tag);
    logic [7:0] v;
    bit idle = 1'b0;
    for (int i = 0; i < 3000 && !idle; i++) begin
      @(negedge clk);
      rd(4'h1, v);
      idle = !v[7];
    end
    checks++;
    if (!idle) begin
      errors++;
      $display("FAIL %s: actual busy expected idle", tag);
    end
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v;
    doReset(4'h0, 4'h0);

    // R1: reset state on every port and on the outputs
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check8("R1 port", v, (a == 0) ? 8'h80 : 8'h00);
    end
    check8("R1 nicReset", {7'h0, nicReset}, 8'h01);
    check8("R1 memEnable", {7'h0, memEnable}, 8'h00);
    check8("R5 no recall on plain reset", {7'h0, nvReq}, 8'h00);

    // vector walk
    for (int i = 0; i < 17; i++) begin
      if (VEC[i].wr) wr(VEC[i].a, VEC[i].d);
      else begin
        rd(VEC[i].a, v);
        check8($sformatf("R%0d vector %0d", VEC[i].rq, i), v, VEC[i].exp);
      end
    end

    // R10: live strap pins on port 1
    strap = 4'h6;
    rd(4'h1, v);
    check8("R10 strap view", v, 8'h06);
    strap = 4'h0;

    // R4: output pins follow the control bits
    wr(4'h0, 8'hC0);
    check8("R4 nicReset set", {7'h0, nicReset}, 8'h01);
    check8("R4 memEnable set", {7'h0, memEnable}, 8'h01);
    wr(4'h0, 8'h40);
    check8("R4 nicReset cleared", {7'h0, nicReset}, 8'h00);
    wr(4'h0, 8'h80);

    // R9: software recall, set 1
    ackCount = 0; expIdx = 0; expSet = 1'b1; seqOk = 1'b1;
    wr(4'h1, 8'h01);
    rd(4'h1, v);
    check8("R9 busy after command", v, 8'h80);
    rd(4'h8, v);
    check8("R7 old value during recall", v, 8'h11);
    wr(4'h8, 8'h99);
    rd(4'h8, v);
    check8("R11 window write ignored", v, 8'h11);
    wr(4'h3, 8'h5A);
    rd(4'h3, v);
    check8("R11 control write accepted", v, 8'h5A);
    waitIdle("R6 software recall completes");
    check8("R6 word count", 8'(ackCount), 8'd16);
    check8("R6 set and order", {7'h0, seqOk}, 8'h01);
    rd(4'h8, v);  check8("R7 address reg 0 loaded", v, 8'hC0);
    rd(4'hF, v);  check8("R7 address reg 7 loaded", v, 8'hC7);
    wr(4'h2, 8'h80);
    rd(4'h8, v);  check8("R6 config reg 0 loaded", v, 8'hC8);
    rd(4'hF, v);  check8("R6 config reg 7 loaded", v, 8'hCF);
    rd(4'h0, v);  check8("R8 software recall keeps control", v, 8'h80);
    check8("R8 nicReset kept", {7'h0, nicReset}, 8'h01);

    // R5: initialisation recall from strap 1001
    ackCount = 0; expIdx = 0; expSet = 1'b0; seqOk = 1'b1;
    doReset(4'h9, 4'h9);
    rd(4'h1, v);
    check8("R5 busy right after reset", v, 8'h89);
    rd(4'h8, v);
    check8("R7 reset value during recall", v, 8'h00);
    waitIdle("R5 init recall completes");
    check8("R6 init word count", 8'(ackCount), 8'd16);
    check8("R6 init set and order", {7'h0, seqOk}, 8'h01);
    rd(4'h8, v);  check8("R6 init address reg 0", v, 8'h40);
    rd(4'hF, v);  check8("R6 init address reg 7", v, 8'h47);
    wr(4'h2, 8'h80);
    rd(4'h8, v);  check8("R6 init config reg 0", v, 8'h48);
    rd(4'hF, v);  check8("R6 init config reg 7", v, 8'h4F);
    rd(4'h0, v);  check8("R8 init forces control bit 7 low", v, 8'h00);
    check8("R8 nicReset released", {7'h0, nicReset}, 8'h00);

    // R5: strap leaves the code before the last reset clock
    ackCount = 0; expIdx = 0;
    doReset(4'h9, 4'h0);
    rd(4'h1, v);
    check8("R5 no busy when strap changed", v, 8'h00);
    repeat (60) @(negedge clk);
    check8("R5 no store requests", 8'(ackCount), 8'd0);

    summary();
    $finish;
  end
endmodule